// File: doc/BRIEF.md
# Register-to-Register ALU for an 8-bit Interpreted Machine

This block carries out the register-to-register group of an 8-bit interpreted virtual machine. An instruction in this group is a 16-bit word whose top nibble is 8. Bits [11:8] name the destination register x, bits [7:4] name the source register y, and the low nibble selects the operation. The surrounding core reads the two operand bytes Vx and Vy from its sixteen-entry register file and presents them here together with the opcode and a valid strobe.

One clock later the block returns the result byte for Vx, a flag byte for the carry/borrow/shift-out register VF (register index 15), separate write enables for each, and the destination index. The core uses those enables to commit the values. The operations are move, OR, AND, XOR, add with carry, subtract, reversed subtract, and one-bit right and left shifts of Vx. Any opcode outside the group, and any unused low nibble, produces no write.

Top module: `rr_alu`

## Requirements
- R1: After reset, res_we_o and flag_we_o are 0, and res_o, flag_o and wr_idx_o are 0.
- R2: Outputs register the request with a latency of one cycle. Whenever valid_i is 1 at a rising edge, wr_idx_o becomes opcode_i[11:8] after that edge. When valid_i is 0, both write enables are 0 after the edge, and res_o, flag_o and wr_idx_o keep their values.
- R3: A valid opcode whose bits [15:12] are not 4'h8 asserts neither write enable, and res_o and flag_o keep their values.
- R4: Low nibbles 0, 1, 2 and 3 give Vy, Vx OR Vy, Vx AND Vy and Vx XOR Vy respectively. They raise res_we_o, keep flag_we_o at 0, and drive flag_o to 0.
- R5: Low nibble 4 gives (Vx+Vy) mod 256. flag_o is 1 when the true sum exceeds 255 and 0 otherwise, and flag_we_o is 1.
- R6: Low nibble 5 gives (Vx−Vy) mod 256. flag_o is 1 when Vx ≥ Vy and 0 otherwise, and flag_we_o is 1.
- R7: Low nibble 7 gives (Vy−Vx) mod 256. flag_o is 1 when Vy ≥ Vx and 0 otherwise, and flag_we_o is 1.
- R8: Low nibble 6 gives Vx shifted right by one with a 0 entering bit 7. flag_o holds the old bit 0 of Vx, and flag_we_o is 1.
- R9: Low nibble 4'hE gives Vx shifted left by one with a 0 entering bit 0. flag_o holds the old bit 7 of Vx, and flag_we_o is 1.
- R10: Low nibbles 8 through 4'hD and 4'hF assert neither write enable, and res_o and flag_o keep their values.
- R11: When x is 4'hF and the operation writes the flag (nibbles 4, 5, 6, 7, 4'hE), res_we_o is 0 and flag_we_o is 1. Logic operations with x equal to 4'hF keep res_we_o at 1.
- R12: flag_o is always 8'h00 or 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe for the opcode and operands |
| opcode_i | input | 16 | Instruction word |
| vx_i | input | 8 | Contents of register x |
| vy_i | input | 8 | Contents of register y |
| res_o | output | 8 | Result byte for register x |
| flag_o | output | 8 | Byte for register VF |
| res_we_o | output | 1 | Commit res_o to register x |
| flag_we_o | output | 1 | Commit flag_o to register VF |
| wr_idx_o | output | 4 | Destination register index x |

## Verification
Every state bit of this block is an output register, so any error in decoding or arithmetic shows at the ports on the edge right after the request. A wrong operation-select, carry or borrow sense, or shift direction changes res_o or flag_o in that very cycle. A wrong enable, or a lost hold on an idle or illegal cycle, shows as a stray or missing write strobe, or as a changed value, one cycle later. The bench compares all five outputs every clock against a behavioural model. It drives directed corner operands (sum of exactly 256, equal operands in subtraction, shifts with edge bits set, destination 4'hF, every illegal nibble) together with random traffic.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;

    typedef enum logic [3:0] {
        FN_MOV  = 4'h0,
        FN_OR   = 4'h1,
        FN_AND  = 4'h2,
        FN_XOR  = 4'h3,
        FN_ADD  = 4'h4,
        FN_SUB  = 4'h5,
        FN_SHR  = 4'h6,
        FN_RSUB = 4'h7,
        FN_SHL  = 4'hE
    } alu_fn_e;

    typedef struct packed {
        logic    accept;   // legal op of this group, load data registers
        logic    res_en;   // result write requested
        logic    flag_en;  // flag write requested
        alu_fn_e fn;
    } alu_ctrl_t;

endpackage

// File: rtl/rr_alu_decode.sv
module rr_alu_decode
    import rr_alu_pkg::*;
#(
    parameter int unsigned NIB_W   = 4,
    parameter logic [3:0]  GROUP   = 4'h8,
    parameter logic [3:0]  FLAG_IX = 4'hF
) (
    input  logic             valid_i,
    input  logic [NIB_W-1:0] group_i,
    input  logic [NIB_W-1:0] dst_i,
    input  logic [NIB_W-1:0] sel_i,
    output alu_ctrl_t        ctrl_o
);
    logic legal_sel;
    logic flag_sel;

    always_comb begin
        legal_sel = 1'b0;
        flag_sel  = 1'b0;
        unique case (sel_i)
            4'h0, 4'h1, 4'h2, 4'h3: legal_sel = 1'b1;
            4'h4, 4'h5, 4'h6, 4'h7, 4'hE: begin
                legal_sel = 1'b1;
                flag_sel  = 1'b1;
            end
            default: legal_sel = 1'b0;
        endcase

        ctrl_o.accept  = valid_i && (group_i == GROUP) && legal_sel;
        ctrl_o.flag_en = ctrl_o.accept && flag_sel;
        // flag write wins when destination is the flag register
        ctrl_o.res_en  = ctrl_o.accept && !(flag_sel && (dst_i == FLAG_IX));
        ctrl_o.fn      = legal_sel ? alu_fn_e'(sel_i) : FN_MOV;
    end
endmodule

// File: rtl/rr_alu_datapath.sv
module rr_alu_datapath
    import rr_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  alu_fn_e           fn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              flag_o
);
    localparam int unsigned EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] sum_w;
    logic [EXT_W-1:0] fwd_diff;
    logic [EXT_W-1:0] rev_diff;

    always_comb begin
        sum_w    = {1'b0, a_i} + {1'b0, b_i};
        fwd_diff = {1'b0, a_i} - {1'b0, b_i};
        rev_diff = {1'b0, b_i} - {1'b0, a_i};
        res_o    = '0;
        flag_o   = 1'b0;
        unique case (fn_i)
            FN_MOV:  res_o = b_i;
            FN_OR:   res_o = a_i | b_i;
            FN_AND:  res_o = a_i & b_i;
            FN_XOR:  res_o = a_i ^ b_i;
            FN_ADD: begin
                res_o  = sum_w[DATA_W-1:0];
                flag_o = sum_w[DATA_W];
            end
            FN_SUB: begin
                res_o  = fwd_diff[DATA_W-1:0];
                flag_o = ~fwd_diff[DATA_W];
            end
            FN_RSUB: begin
                res_o  = rev_diff[DATA_W-1:0];
                flag_o = ~rev_diff[DATA_W];
            end
            FN_SHR: begin
                res_o  = {1'b0, a_i[DATA_W-1:1]};
                flag_o = a_i[0];
            end
            FN_SHL: begin
                res_o  = {a_i[DATA_W-2:0], 1'b0};
                flag_o = a_i[DATA_W-1];
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/rr_alu.sv
module rr_alu
    import rr_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OP_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [DATA_W-1:0] vx_i,
    input  logic [DATA_W-1:0] vy_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] flag_o,
    output logic              res_we_o,
    output logic              flag_we_o,
    output logic [3:0]        wr_idx_o
);
    localparam int unsigned NIB_W = 4;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] flag;
        logic              res_we;
        logic              flag_we;
        logic [NIB_W-1:0]  idx;
    } st_t;

    st_t st_d, st_q;

    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] dp_res;
    logic              dp_flag;

    rr_alu_decode #(.NIB_W(NIB_W)) u_dec (
        .valid_i (valid_i),
        .group_i (opcode_i[OP_W-1 -: NIB_W]),
        .dst_i   (opcode_i[11:8]),
        .sel_i   (opcode_i[NIB_W-1:0]),
        .ctrl_o  (ctrl)
    );

    rr_alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .fn_i   (ctrl.fn),
        .a_i    (vx_i),
        .b_i    (vy_i),
        .res_o  (dp_res),
        .flag_o (dp_flag)
    );

    always_comb begin
        st_d         = st_q;
        st_d.res_we  = ctrl.res_en;
        st_d.flag_we = ctrl.flag_en;
        if (valid_i) begin
            st_d.idx = opcode_i[11:8];
        end
        if (ctrl.accept) begin
            st_d.res  = dp_res;
            st_d.flag = {{(DATA_W-1){1'b0}}, dp_flag};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o     = st_q.res;
    assign flag_o    = st_q.flag;
    assign res_we_o  = st_q.res_we;
    assign flag_we_o = st_q.flag_we;
    assign wr_idx_o  = st_q.idx;

    // R2: idle cycle writes nothing and holds data
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !res_we_o && !flag_we_o && $stable(res_o) && $stable(flag_o));

    // R2: destination index follows the request
    a_r2_idx_follow: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> wr_idx_o == $past(opcode_i[11:8]));

    // R3: foreign groups never write
    a_r3_foreign_group: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && opcode_i[15:12] != 4'h8 |=> !res_we_o && !flag_we_o);

    // R5: carry out of the addition
    a_r5_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && opcode_i[15:12] == 4'h8 && opcode_i[3:0] == 4'h4
        |=> flag_o[0] == ((9'($past(vx_i)) + 9'($past(vy_i))) > 9'd255));

    // R10: illegal low nibbles never write
    a_r10_illegal_sel: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && opcode_i[15:12] == 4'h8 && (opcode_i[3:0] inside {[4'h8:4'hD], 4'hF})
        |=> !res_we_o && !flag_we_o);

    // R11: flag register destination, flag write takes priority
    a_r11_vf_priority: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && opcode_i[15:8] == 8'h8F && (opcode_i[3:0] inside {[4'h4:4'h7], 4'hE})
        |=> flag_we_o && !res_we_o);

    // R12: flag byte carries a single bit
    a_r12_flag_bit: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o[DATA_W-1:1] == '0);
endmodule

// File: tb/rr_alu_tb.sv
module rr_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] opcode_i = '0;
    logic [7:0]  vx_i = '0;
    logic [7:0]  vy_i = '0;
    logic [7:0]  res_o, flag_o;
    logic        res_we_o, flag_we_o;
    logic [3:0]  wr_idx_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    int m_res = 0, m_flag = 0, m_rwe = 0, m_fwe = 0, m_idx = 0;

    always #10 clk = ~clk;

    rr_alu u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .vx_i(vx_i), .vy_i(vy_i), .res_o(res_o), .flag_o(flag_o),
        .res_we_o(res_we_o), .flag_we_o(flag_we_o), .wr_idx_o(wr_idx_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk(req, "res_o", int'(res_o), m_res);
        chk(req, "flag_o", int'(flag_o), m_flag);
        chk(req, "res_we_o", int'(res_we_o), m_rwe);
        chk(req, "flag_we_o", int'(flag_we_o), m_fwe);
        chk(req, "wr_idx_o", int'(wr_idx_o), m_idx);
    endtask

    // behavioural model of one accepted request
    task automatic model(bit v, int op, int a, int b);
        int n, x, r, f;
        bit legal, fl;
        m_rwe = 0;
        m_fwe = 0;
        if (!v) return;
        m_idx = (op >> 8) & 15;
        if (((op >> 12) & 15) != 8) return;
        n = op & 15;
        x = (op >> 8) & 15;
        legal = 1; fl = 1; r = 0; f = 0;
        case (n)
            0: begin r = b; fl = 0; end
            1: begin r = a | b; fl = 0; end
            2: begin r = a & b; fl = 0; end
            3: begin r = a ^ b; fl = 0; end
            4: begin r = (a + b) % 256; f = (a + b > 255) ? 1 : 0; end
            5: begin r = (a - b + 256) % 256; f = (a >= b) ? 1 : 0; end
            7: begin r = (b - a + 256) % 256; f = (b >= a) ? 1 : 0; end
            6: begin r = a / 2; f = a % 2; end
            14: begin r = (a * 2) % 256; f = a / 128; end
            default: legal = 0;
        endcase
        if (!legal) return;
        m_res = r;
        m_flag = f;
        m_fwe = fl;
        m_rwe = (fl && x == 15) ? 0 : 1;
    endtask

    // drive after a falling edge, compare at the next falling edge
    task automatic step(bit v, int op, int a, int b, string req);
        valid_i = v;
        opcode_i = 16'(op);
        vx_i = 8'(a);
        vy_i = 8'(b);
        model(v, op, a, b);
        @(negedge clk);
        chk_all(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        // R4 logic group and moves, including destination F
        step(1, 'h8120, 'hA5, 'h3C, "R4");
        step(1, 'h8231, 'hA5, 'h3C, "R4");
        step(1, 'h8342, 'hA5, 'h3C, "R4");
        step(1, 'h8F53, 'hA5, 'h3C, "R4_R11");
        // R5 add with and without carry, exact 256
        step(1, 'h8014, 'hFF, 'h01, "R5");
        step(1, 'h8014, 'h7F, 'h80, "R5");
        step(1, 'h8014, 'h80, 'h80, "R5");
        // R6 subtract: equal, less, greater
        step(1, 'h8125, 'h40, 'h40, "R6");
        step(1, 'h8125, 'h10, 'h11, "R6");
        step(1, 'h8125, 'h90, 'h11, "R6");
        // R7 reversed subtract
        step(1, 'h8237, 'h40, 'h40, "R7");
        step(1, 'h8237, 'h41, 'h40, "R7");
        step(1, 'h8237, 'h01, 'hF0, "R7");
        // R8 and R9 shifts with edge bits
        step(1, 'h8346, 'h81, 'h00, "R8");
        step(1, 'h8346, 'h80, 'hFF, "R8");
        step(1, 'h834E, 'h81, 'h00, "R9");
        step(1, 'h834E, 'h7F, 'hFF, "R9");
        // R11 destination F with flag operations
        step(1, 'h8F04, 'hFF, 'hFF, "R11");
        step(1, 'h8F06, 'h03, 'h00, "R11");
        step(1, 'h8F0E, 'h80, 'h00, "R11");
        step(1, 'h8F05, 'h01, 'h02, "R11");
        // R10 every illegal low nibble, data must hold
        for (int n = 8; n < 16; n++) begin
            if (n != 14) step(1, 'h8A00 | n, 'h55, 'hAA, "R10");
        end
        // R3 foreign groups
        step(1, 'h7A14, 'h12, 'h34, "R3");
        step(1, 'hF033, 'h12, 'h34, "R3");
        step(1, 'h0E00, 'h12, 'h34, "R3");
        // R2 idle cycles hold everything
        step(1, 'h8564, 'hC8, 'h64, "R2");
        step(0, 'h8E24, 'h01, 'h01, "R2");
        step(0, 'h0000, 'h00, 'h00, "R2");
        // R12 plus random traffic across all of the above
        for (int i = 0; i < 2000; i++) begin
            int op;
            op = int'($urandom_range(0, 65535));
            if ($urandom_range(0, 3) != 0) op = (op & 'h0FFF) | 'h8000;
            step($urandom_range(0, 7) != 0, op,
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), "R12_rand");
        end
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule